// File: doc/BRIEF.md
# JTAG debug transmit mailbox

This block hands one data word from debug software running on the core to an external debugger that reaches the chip through its JTAG test access port. Software writes a word into a transmit register. The write raises a ready flag that software can read but cannot write. The debugger selects the mailbox with a dedicated instruction and captures a scan chain of `DATA_W+3` bits. Bit 0 of that chain is the ready flag, bits 2 and 1 are zero, and the word sits above them. The debugger then shifts the chain out on TDO.

When the debugger shifts the chain right after capturing a ready flag of 1, it has taken the word, and the flag is cleared automatically. The clear request crosses from the test clock into the core clock through a toggle and a synchronizer, so that each read clears the flag once. In the other direction, the ready flag is synchronized into the test clock before the capture logic uses it. The word is sampled only when that synchronized flag is 1. Bits shifted in from TDI never reach the transmit register.

The block takes the TAP controller's state strobes as inputs and does not contain the controller itself.

Top module: `jtag_tx_mailbox`

## Requirements
- R1: After reset, `tr_flag` is 0, and `tdo` is 0 until the first capture.
- R2: A core-clock edge with `sw_wr` high loads `sw_wdata` into the transmit register and sets `tr_flag`, which is visible after that edge.
- R3: With `ir` equal to 7'b0010000, a capture loads bit 0 with the synchronized ready flag and bits [2:1] with 0. When that flag is 1, it also loads bits [34:3] with the transmit word. Each shift edge moves the chain one place toward bit 0 and enters `tdi` at bit 34, and `tdo` shows bit 0, so the chain leaves least significant bit first.
- R4: A capture taken while the ready flag is 0 yields 0 in bit 0. Bits [34:3] are then unspecified.
- R5: A shift edge that immediately follows a capture of 1 in bit 0 clears `tr_flag`. The clear takes effect on the third rising core-clock edge after that test-clock edge, and it happens once.
- R6: A capture followed by an idle test-clock edge before shifting does not clear `tr_flag`.
- R7: Bits shifted in from `tdi` and the update strobe never change the transmit word.
- R8: When a software write and the clear land on the same core-clock edge, `tr_flag` ends at 1 and the new word is kept.
- R9: With any other instruction in `ir`, the strobes have no effect, `tdo` is 0 and `tr_flag` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sw_wr | input | 1 | Software write strobe to the transmit register |
| sw_wdata | input | 32 | Word written by software |
| tr_flag | output | 1 | Ready flag, readable by software |
| tck | input | 1 | Test clock |
| ir | input | 7 | Current JTAG instruction |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 35-bit chain and the 7-bit instruction 7'b0010000. It runs the core clock at four times the test-clock rate, with the edges of the two clocks offset, so the bench can place a software write on exactly the core edge where a debugger clear lands. This exercises the set-over-clear case of R8. A behavioural model tracks the ready flag and every captured bit, and it is compared with `tr_flag` on each core clock and with `tdo` on each test clock. Empty captures, reads that pause before shifting, TDI traffic followed by update, and scans under a foreign instruction are all run against the same model.

// File: rtl/jtag_tx_mailbox.sv
module jtag_tx_mailbox #(
  parameter int DATA_W = 32,
  parameter int IR_W = 7,
  parameter logic [IR_W-1:0] IR_CODE = 7'b0010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic              tr_flag,
  input  logic              tck,
  input  logic [IR_W-1:0]   ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo
);
  localparam int CHAIN_W = DATA_W + 3;

  logic [DATA_W-1:0]  tx_q;
  logic               tr_q;
  logic [2:0]         clr_sync;
  logic               clr_tgl;
  logic [1:0]         tr_sync;
  logic [CHAIN_W-1:0] chain;
  logic               cap_prev, cap_one;

  wire clr_pulse = clr_sync[1] ^ clr_sync[2];
  wire sel = (ir == IR_CODE);
  wire cap = sel & capture_dr;
  wire sh  = sel & shift_dr;

  assign tr_flag = tr_q;
  assign tdo = sel & chain[0];

  // core domain: word, flag, clear synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      tr_q <= 1'b0;
      clr_sync <= '0;
    end else begin
      clr_sync <= {clr_sync[1:0], clr_tgl};
      if (sw_wr) begin
        tx_q <= sw_wdata;
        tr_q <= 1'b1;
      end else if (clr_pulse) begin
        tr_q <= 1'b0;
      end
    end
  end

  // test-clock domain: flag synchronizer, chain, clear toggle
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tr_sync <= '0;
      chain <= '0;
      cap_prev <= 1'b0;
      cap_one <= 1'b0;
      clr_tgl <= 1'b0;
    end else begin
      tr_sync <= {tr_sync[0], tr_q};
      cap_prev <= cap;
      if (cap) begin
        chain[0] <= tr_sync[1];
        chain[2:1] <= 2'b00;
        if (tr_sync[1]) chain[CHAIN_W-1:3] <= tx_q;
        cap_one <= tr_sync[1];
      end else if (sh) begin
        chain <= {tdi, chain[CHAIN_W-1:1]};
        if (cap_prev && cap_one) clr_tgl <= ~clr_tgl;
      end
    end
  end

  p_write_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> tr_q && tx_q == $past(sw_wdata));
  p_flag_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tr_q) |-> $past(sw_wr));
  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> $stable(tx_q));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && clr_pulse) |=> tr_q);
  p_capture_fmt_r3: assert property (@(posedge tck) disable iff (!rst_n)
    cap |=> chain[2:1] == 2'b00 && chain[0] == $past(tr_sync[1]));
  p_shift_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (sh && !cap) |=> chain[CHAIN_W-2:0] == $past(chain[CHAIN_W-1:1])
                     && chain[CHAIN_W-1] == $past(tdi));
  p_update_inert_r7: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && update_dr && !capture_dr && !shift_dr) |=> $stable(chain));
  p_unselected_r9: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |=> $stable(chain) && $stable(clr_tgl));
endmodule

// File: tb/jtag_tx_mailbox_bench.sv
module jtag_tx_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TCK_PERIOD = 4 * CLK_PERIOD;
  localparam logic [6:0] SEL_IR = 7'b0010000;

  logic clk = 1'b0, tck = 1'b0, rst_n = 1'b0;
  logic sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic [6:0] ir = '0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tr_flag, tdo;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(TCK_PERIOD/2) tck = ~tck;

  jtag_tx_mailbox u_jtag_tx_mailbox (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .tr_flag(tr_flag),
    .tck(tck), .ir(ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_tr = 0, m_s1 = 0, m_s2 = 0, m_prevcap = 0, m_cap1 = 0;
  logic [31:0] m_tx = '0;
  logic [34:0] m_chain = '0, m_known = '1;
  int clr_cd = 0;

  always @(posedge clk) if (rst_n) begin
    if (sw_wr) begin m_tr = 1; m_tx = sw_wdata; end
    else if (clr_cd == 1) m_tr = 0;
    if (clr_cd > 0) clr_cd--;
  end

  always @(posedge tck) if (rst_n) begin
    bit c, s;
    c = (ir == SEL_IR) && capture_dr;
    s = (ir == SEL_IR) && shift_dr;
    if (c) begin
      m_chain[0] = m_s2;
      m_chain[2:1] = 2'b00;
      if (m_s2) begin m_chain[34:3] = m_tx; m_known = '1; end
      else m_known = 35'h7;
      m_cap1 = m_s2;
    end else if (s) begin
      if (m_prevcap && m_cap1) clr_cd = 3;
      m_chain = {tdi, m_chain[34:1]};
      m_known = {1'b1, m_known[34:1]};
    end
    m_prevcap = c;
    m_s2 = m_s1;
    m_s1 = m_tr;
  end

  always @(negedge clk) if (rst_n) begin
    #2;
    check(tr_flag == m_tr, "R2/R5 flag vs model", tr_flag, m_tr);
  end

  always @(negedge tck) if (rst_n) begin
    #2;
    if (ir != SEL_IR) check(tdo == 1'b0, "R9 tdo vs model", tdo, 0);
    else if (m_known[0]) check(tdo == m_chain[0], "R3 tdo vs model", tdo, m_chain[0]);
  end

  task automatic sw_write(input logic [31:0] d);
    @(negedge clk); sw_wr = 1; sw_wdata = d;
    @(negedge clk); sw_wr = 0;
    repeat (4) @(negedge tck);
  endtask

  task automatic scan(input logic [6:0] instr, input bit gap, input logic [34:0] pat,
                      input bit ovl, input logic [31:0] ovl_word, output logic [34:0] got);
    @(negedge tck); ir = instr; capture_dr = 1;
    @(negedge tck); capture_dr = 0;
    if (gap) @(negedge tck);
    shift_dr = 1;
    for (int k = 0; k < 35; k++) begin
      tdi = pat[k];
      #2 got[k] = tdo;
      @(negedge tck);
      if (ovl && k == 0) fork
        begin sw_wr = 1; sw_wdata = ovl_word; @(negedge clk); sw_wr = 0; end
      join_none
    end
    shift_dr = 0; update_dr = 1;
    @(negedge tck); update_dr = 0;
    repeat (3) @(negedge tck);
  endtask

  initial begin
    logic [34:0] got;
    repeat (3) @(negedge tck);
    #2;
    check(tr_flag == 0, "R1 reset flag", tr_flag, 0);
    check(tdo == 0, "R1 reset tdo", tdo, 0);
    rst_n = 1;
    @(negedge tck); #2;
    check(tdo == 0, "R1 tdo after release", tdo, 0);

    scan(SEL_IR, 0, '0, 0, '0, got);
    check(got[2:0] == 3'b000, "R4 empty capture", got[2:0], 0);

    sw_write(32'hA5C3_0F96);
    check(tr_flag == 1, "R2 flag after write", tr_flag, 1);
    scan(7'h0, 0, '1, 0, '0, got);
    check(got == '0, "R9 unselected tdo", got, 0);
    check(tr_flag == 1, "R9 flag kept", tr_flag, 1);

    scan(SEL_IR, 0, 35'h5_5555_5555, 0, '0, got);
    check(got == {32'hA5C3_0F96, 3'b001}, "R3 read word", got, {32'hA5C3_0F96, 3'b001});
    check(tr_flag == 0, "R5 flag cleared", tr_flag, 0);
    scan(SEL_IR, 0, '0, 0, '0, got);
    check(got[2:0] == 3'b000, "R5 second capture empty", got[2:0], 0);

    sw_write(32'h1234_8001);
    scan(SEL_IR, 1, 35'h7_FFFF_FFFF, 0, '0, got);
    check(got == {32'h1234_8001, 3'b001}, "R6 paused read word", got, {32'h1234_8001, 3'b001});
    check(tr_flag == 1, "R6 flag kept after pause", tr_flag, 1);
    scan(SEL_IR, 0, '0, 0, '0, got);
    check(got == {32'h1234_8001, 3'b001}, "R7 word after tdi and update", got, {32'h1234_8001, 3'b001});
    check(tr_flag == 0, "R5 flag cleared again", tr_flag, 0);

    sw_write(32'hDEAD_0042);
    scan(SEL_IR, 0, '0, 1, 32'hBEEF_7711, got);
    check(got == {32'hDEAD_0042, 3'b001}, "R3 read before overlap", got, {32'hDEAD_0042, 3'b001});
    check(tr_flag == 1, "R8 set wins", tr_flag, 1);
    scan(SEL_IR, 0, '0, 0, '0, got);
    check(got == {32'hBEEF_7711, 3'b001}, "R8 new word kept", got, {32'hBEEF_7711, 3'b001});
    check(tr_flag == 0, "R5 final clear", tr_flag, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule